// File: doc/BRIEF.md
# Reset Cause Status Recorder

This block keeps two status registers for a reset controller. The cause register records which request lines led to a reset. The RAM register records which memories were wiped during the most recent reset. The block watches the cold and warm request lines, the completion pulses from the sequencer and per-RAM clear flags. At each completion it updates the registers under separate cold and warm rules.

A cold completion leaves only the cold source or sources that released last. When several overlapping cold requests are active, the block remembers which of them let go last, or which let go together in the same cycle. A warm completion adds its sources to whatever is already recorded. Software clears bits through a write-one-to-clear port and reads both registers through a port with a one-cycle read latency.

Top module: `reset_cause_recorder`

## Requirements
- R1: After reset is released, both status registers and `rd_data` are zero.
- R2: In the cause register, bit i (0 ≤ i < N_COLD) stands for cold request line i and bit N_COLD+j stands for warm request line j. When `cold_done` pulses, every warm bit is cleared and the cold bits equal the recorded cold source set.
- R3: When cold requests overlap and release in different cycles, only the line that released last is recorded.
- R4: When several cold lines release in the same cycle, and no line releases later, all of them are recorded.
- R5: When `warm_done` pulses, each warm line that was high in any cycle since the previous completion pulse has its bit set. Every bit already set stays set.
- R6: A write with `wr_en` high and `wr_addr` = 0 clears each cause bit whose `wr_data` bit is 1. Bits written with 0 keep their value, and the registers do not change in a cycle with no write and no completion pulse.
- R7: If a warm completion sets a bit in the same cycle that software clears it, the bit ends up set.
- R8: On any completion pulse, the RAM register is replaced by the set of RAM flags seen high since the previous completion pulse, including the pulse cycle. A write to `wr_addr` = 1 clears the RAM bits written with 1.
- R9: A read with `rd_en` high returns the register at `rd_addr` on `rd_data` after the next clock edge, zero-extended: address 0 gives the cause register, address 1 gives the RAM register and any other address gives 0. While `rd_en` is low, `rd_data` holds its value.
- R10: When `cold_done` and `warm_done` pulse in the same cycle, the cold rule alone applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cold_req | input | N_COLD | Cold reset request lines |
| warm_req | input | N_WARM | Warm reset request lines |
| cold_done | input | 1 | One-cycle pulse: cold reset finished |
| warm_done | input | 1 | One-cycle pulse: warm reset finished |
| ram_clr_done | input | N_RAM | Per-RAM flag: memory cleared |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 cause, 1 RAM) |
| wr_data | input | DW | Write-one-to-clear mask |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | DW | Read data, valid one edge after the strobe |

## Verification
A completion pulse or a write updates the registers at the clock edge that samples it. A read strobe puts the value on `rd_data` one edge later, so a status value can first be seen on `rd_data` two edges after its completion pulse. The bench drives every input 1 ns after a rising edge. It starts each read only after the pulse or write has been sampled, and it samples `rd_data` 1 ns after the edge that samples `rd_en`. Each result is therefore compared in the cycle it is due, with no extra waiting.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  parameter int unsigned RCR_AW = 2;

  typedef enum logic [RCR_AW-1:0] {
    RCR_ADDR_CAUSE = 2'd0,
    RCR_ADDR_RAM   = 2'd1
  } rcr_addr_e;
endpackage

// File: rtl/rcr_cold_track.sv
module rcr_cold_track #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         done,
  output logic [N-1:0] src
);
  logic [N-1:0] prev_q;
  logic [N-1:0] last_q;
  logic [N-1:0] last_d;
  logic [N-1:0] fell;

  // lines that released this cycle replace the held set
  always_comb begin
    fell   = prev_q & ~req;
    last_d = last_q;
    if (done)       last_d = '0;
    else if (|fell) last_d = fell;
    src = (|fell) ? fell : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      last_q <= '0;
    end else begin
      prev_q <= req;
      last_q <= last_d;
    end
  end

  AST_RELEASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(prev_q & ~req)) && !done) |=> (last_q != '0)); // R3
  AST_DONE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (last_q == '0)); // R2
endmodule

// File: rtl/rcr_accum.sv
module rcr_accum #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags,
  input  logic         capture,
  input  logic         flush,
  output logic [W-1:0] seen
);
  logic [W-1:0] acc_q;
  logic [W-1:0] acc_d;

  always_comb begin
    seen  = acc_q | flags;
    acc_d = (capture || flush) ? '0 : seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_ACC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !flush) |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R5
endmodule

// File: rtl/rcr_readback.sv
module rcr_readback
  import rcr_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 8,
  parameter int unsigned RW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [RCR_AW-1:0] rd_addr,
  input  logic [SW-1:0]     cause,
  input  logic [RW-1:0]     ramst,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] rd_q;
  logic [DW-1:0] rd_d;

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      rd_d = '0;
      case (rd_addr)
        RCR_ADDR_CAUSE: rd_d[SW-1:0] = cause;
        RCR_ADDR_RAM:   rd_d[RW-1:0] = ramst;
        default:        rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R9
endmodule

// File: rtl/reset_cause_recorder.sv
module reset_cause_recorder
  import rcr_pkg::*;
#(
  parameter int unsigned N_COLD = 4,
  parameter int unsigned N_WARM = 4,
  parameter int unsigned N_RAM  = 6,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_COLD-1:0] cold_req,
  input  logic [N_WARM-1:0] warm_req,
  input  logic              cold_done,
  input  logic              warm_done,
  input  logic [N_RAM-1:0]  ram_clr_done,
  input  logic              wr_en,
  input  logic [RCR_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [RCR_AW-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);
  localparam int unsigned SW = N_COLD + N_WARM;

  logic [N_COLD-1:0] cold_src;
  logic [N_WARM-1:0] warm_src;
  logic [N_RAM-1:0]  ram_src;
  logic [SW-1:0]     cause_q, cause_d, clr_cause;
  logic [N_RAM-1:0]  ram_q, ram_d, clr_ram;
  logic              cause_en, ram_en, any_done;

  rcr_cold_track #(.N(N_COLD)) u_cold (
    .clk(clk), .rst_n(rst_n), .req(cold_req), .done(cold_done), .src(cold_src)
  );

  rcr_accum #(.W(N_WARM)) u_warm_acc (
    .clk(clk), .rst_n(rst_n), .flags(warm_req),
    .capture(warm_done), .flush(cold_done), .seen(warm_src)
  );

  rcr_accum #(.W(N_RAM)) u_ram_acc (
    .clk(clk), .rst_n(rst_n), .flags(ram_clr_done),
    .capture(any_done), .flush(1'b0), .seen(ram_src)
  );

  // next-state: cold wipes, warm ORs in over the software clear
  always_comb begin
    any_done  = cold_done | warm_done;
    clr_cause = (wr_en && (wr_addr == RCR_ADDR_CAUSE)) ? wr_data[SW-1:0] : '0;
    clr_ram   = (wr_en && (wr_addr == RCR_ADDR_RAM))   ? wr_data[N_RAM-1:0] : '0;
    cause_en  = any_done | (|clr_cause);
    ram_en    = any_done | (|clr_ram);
    if (cold_done)
      cause_d = {{N_WARM{1'b0}}, cold_src};
    else if (warm_done)
      cause_d = (cause_q & ~clr_cause) | {warm_src, {N_COLD{1'b0}}};
    else
      cause_d = cause_q & ~clr_cause;
    ram_d = any_done ? ram_src : (ram_q & ~clr_ram);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      ram_q   <= '0;
    end else begin
      if (cause_en) cause_q <= cause_d;
      if (ram_en)   ram_q   <= ram_d;
    end
  end

  rcr_readback #(.DW(DW), .SW(SW), .RW(N_RAM)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .cause(cause_q), .ramst(ram_q), .rd_data(rd_data)
  );

  AST_COLD_WIPES_WARM: assert property (@(posedge clk) disable iff (!rst_n)
    cold_done |=> (cause_q[SW-1:N_COLD] == '0)); // R2
  AST_WARM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_done && !cold_done && !wr_en) |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R5
  AST_W1C_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RCR_ADDR_CAUSE && !cold_done && !warm_done) |=>
      ((cause_q & ~$past(wr_data[SW-1:0])) == ($past(cause_q) & ~$past(wr_data[SW-1:0])))); // R6
  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_done && !cold_done) |=> ((cause_q[SW-1:N_COLD] & $past(warm_src)) == $past(warm_src))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cold_done && !warm_done && !wr_en) |=> ($stable(cause_q) && $stable(ram_q))); // R6
endmodule

// File: tb/reset_cause_recorder_bench.sv
`timescale 1ns/1ps
module reset_cause_recorder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cold_req, warm_req;
  logic        cold_done, warm_done;
  logic [5:0]  ram_clr_done;
  logic        wr_en, rd_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data;
  wire  [31:0] rd_data;

  int n_run  = 0;
  int n_fail = 0;
  bit over   = 1'b0;

  always #2.5 clk = ~clk;

  reset_cause_recorder u_reset_cause_recorder (
    .clk(clk), .rst_n(rst_n), .cold_req(cold_req), .warm_req(warm_req),
    .cold_done(cold_done), .warm_done(warm_done), .ram_clr_done(ram_clr_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_en = 1'b1; rd_addr = a;
    step();
    v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic cold_pulse();
    cold_done = 1'b1; step(); cold_done = 1'b0;
  endtask

  task automatic warm_pulse();
    warm_done = 1'b1; step(); warm_done = 1'b0;
  endtask

  task automatic cold_simul(input logic [3:0] m);
    cold_req = m; step(); cold_req = '0; step(); cold_pulse();
  endtask

  task automatic warm_ep(input logic [3:0] m, input logic [5:0] ram);
    warm_req = m; ram_clr_done = ram; step();
    warm_req = '0; ram_clr_done = '0; step(); warm_pulse();
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, hold;
    logic [3:0]  acc;
    rst_n = 1'b0; cold_req = '0; warm_req = '0; cold_done = 1'b0; warm_done = 1'b0;
    ram_clr_done = '0; wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 rd_data", rd_data, 32'h0);
    rd(2'd0, v); chk("R1 cause", v, 32'h0);
    rd(2'd1, v); chk("R1 ram", v, 32'h0);

    // R4 / R2: simultaneous release, warm bits wiped
    for (int m = 1; m < 16; m++) begin
      warm_ep(4'hF, 6'h0);
      cold_simul(4'(m));
      rd(2'd0, v); chk("R4 simultaneous cold", v, 32'(m));
    end

    // R3: overlap, last release recorded
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        if (a != b) begin
          cold_req = 4'((1 << a) | (1 << b)); step();
          cold_req = 4'(1 << b); step();
          cold_req = '0; step();
          cold_pulse();
          rd(2'd0, v); chk("R3 last release", v, 32'(1 << b));
        end

    // R5: warm accumulation keeps cold bit
    cold_simul(4'h1);
    acc = '0;
    for (int m = 1; m < 16; m++) begin
      warm_ep(4'(m), 6'h0);
      acc = acc | 4'(m);
      rd(2'd0, v); chk("R5 warm accumulate", v, 32'h1 | (32'(acc) << 4));
    end

    // R6: write-one-to-clear sweep
    for (int w = 0; w < 256; w++) begin
      cold_simul(4'hF);
      warm_ep(4'hF, 6'h0);
      wr(2'd0, 32'(w) | 32'hFFFF_FF00);
      rd(2'd0, v); chk("R6 w1c cause", v, 32'hFF & ~32'(w));
    end

    // R7: hardware set beats software clear
    for (int m = 1; m < 16; m++) begin
      cold_simul(4'hF);
      warm_req = 4'(m); step(); warm_req = '0; step();
      warm_done = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'hFF; step();
      warm_done = 1'b0; wr_en = 1'b0; wr_data = '0;
      rd(2'd0, v); chk("R7 set wins", v, 32'(m) << 4);
    end

    // R10: both done pulses together follow cold rule
    warm_req = 4'h3; step(); warm_req = '0; step();
    cold_req = 4'h4; step(); cold_req = '0; step();
    cold_done = 1'b1; warm_done = 1'b1; step(); cold_done = 1'b0; warm_done = 1'b0;
    rd(2'd0, v); chk("R10 cold over warm", v, 32'h4);

    // R8: RAM status replaced each completion, w1c at address 1
    for (int m = 0; m < 64; m++) begin
      cold_req = 4'h1; ram_clr_done = 6'(m) & 6'h15; step();
      cold_req = '0;   ram_clr_done = 6'(m) & 6'h2A; step();
      ram_clr_done = '0;
      cold_pulse();
      rd(2'd1, v); chk("R8 ram replace", v, 32'(m));
      wr(2'd1, 32'h0F);
      rd(2'd1, v); chk("R8 ram w1c", v, 32'(m) & 32'h30);
    end
    warm_ep(4'h0, 6'h21);
    warm_ep(4'h0, 6'h00);
    rd(2'd1, v); chk("R8 ram cleared by empty reset", v, 32'h0);

    // R9: unmapped reads and hold
    rd(2'd2, v); chk("R9 unmapped 2", v, 32'h0);
    rd(2'd3, v); chk("R9 unmapped 3", v, 32'h0);
    cold_simul(4'h2);
    rd(2'd0, hold); chk("R9 read cause", hold, 32'h2);
    warm_ep(4'h8, 6'h3);
    chk("R9 hold while idle", rd_data, hold);
    rd(2'd0, v); chk("R9 fresh read", v, 32'h82);

    finish_run();
  end
endmodule